// File: doc/BRIEF.md
# I2C Interrupt Flag Event Logic

This block produces the single interrupt request flag of an I2C controller. It synchronizes the SCL and SDA lines to the system clock, detects start and stop conditions, and counts SCL clocks within each 9-clock byte frame. It combines these bus events with the controller's mode bits and with event strobes from neighbouring logic. From that it decides when the interrupt flag must be raised.

Master and slave mode raise the flag on different events. The wait, acknowledge-check, arbitration-loss-enable and stop-mask controls add or remove events. The CPU clears the flag through a one-bit write port. The block also keeps two status bits: the last acknowledge bit sampled on the 9th clock, and a record that a stop condition was seen in slave mode.

Top module: `i2c_irq_flag`

## Requirements
- R1: In master mode, a start condition seen on the bus while a first-frame strobe (`first_frame_i`) is pending sets the flag. The strobe stays pending until that start condition. A start condition with no pending strobe does not set the flag.
- R2: In master mode with `wait_en_i`=1, the falling edge of the 8th SCL clock of a frame sets the flag. With `wait_en_i`=0 that edge sets nothing.
- R3: In master mode, the rising edge of the 9th SCL clock of every frame sets the flag.
- R4: On every 9th-clock rise, the SDA level is latched into `ack_bit_o`. If `ack_chk_i`=1 and that level is 1, the flag is set in either mode.
- R5: In master mode with `al_ie_i`=1, an `arb_lost_i` strobe sets the flag. After any `arb_lost_i`, an `addr_match_i` or `gcall_i` strobe sets the flag until the next stop condition.
- R6: In slave mode, an `addr_match_i` or `gcall_i` strobe makes the block active. While it is active, every 9th-clock rise sets the flag. A start or stop condition ends the active state.
- R7: In slave mode, a stop condition sets `stop_seen_o`, and it also sets the flag only if `stop_mask_i`=0. `stop_seen_o` clears on the next start condition.
- R8: The flag clears only when `wr_en_i`=1 with `wr_flag_i`=0. Writing 1 leaves the flag unchanged.
- R9: When a set event and a clearing write occur in the same cycle, the flag ends the cycle at 1.
- R10: A start or stop condition restarts the frame clock count, so that the next 9th-clock event counts from that condition.
- R11: After reset, `irq_o`, `ack_bit_o` and `stop_seen_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line, asynchronous |
| sda_i | input | 1 | SDA line, asynchronous |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| wait_en_i | input | 1 | Raise the flag at the 8th clock fall (master) |
| ack_chk_i | input | 1 | Raise the flag when the acknowledge bit is 1 |
| al_ie_i | input | 1 | Raise the flag on arbitration loss |
| stop_mask_i | input | 1 | 1 = no flag on stop in slave mode |
| arb_lost_i | input | 1 | Strobe: arbitration lost |
| addr_match_i | input | 1 | Strobe: own slave address matched |
| gcall_i | input | 1 | Strobe: general call with write direction |
| first_frame_i | input | 1 | Strobe: master has issued a start, first frame pending |
| wr_en_i | input | 1 | Flag write enable |
| wr_flag_i | input | 1 | Flag write value (only 0 has an effect) |
| irq_o | output | 1 | Interrupt request flag |
| ack_bit_o | output | 1 | Last acknowledge bit sampled on the 9th clock |
| stop_seen_o | output | 1 | Stop condition seen in slave mode |

## Verification
The hardest case to reach is a set event and a software clear landing in the same clock. The bus events pass through the synchronizer, so their timing is awkward to hit exactly. The bench therefore uses the arbitration-loss strobe, which reaches the set logic in the same cycle it is driven, and drives the clearing write on that same edge. The restart of the frame counter is also tested: a repeated start is issued after three clocks of a byte, and the bench confirms that the 9th-clock event follows the count from the new start and not from the old one.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int unsigned FRAME_CLKS = 9;
  localparam int unsigned CNT_W      = $clog2(FRAME_CLKS + 1);

  typedef struct packed {
    logic start;
    logic stop;
    logic fall8;
    logic rise9;
    logic sda;
  } frame_evt_t;

  typedef struct packed {
    logic master;
    logic wait_en;
    logic ack_chk;
    logic al_ie;
    logic stop_mask;
  } irq_ctrl_t;

  typedef struct packed {
    logic arb_lost;
    logic addr_match;
    logic gcall;
    logic first_frame;
  } ext_evt_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= line_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/i2c_frame_mon.sv
module i2c_frame_mon
  import i2c_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_lvl_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_lvl_i,
  input  logic       sda_rise_i,
  input  logic       sda_fall_i,
  output frame_evt_t evt_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_CLKS);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(FRAME_CLKS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_c, stop_c;

  // SDA edges while SCL is high are bus conditions
  assign start_c = sda_fall_i & scl_lvl_i;
  assign stop_c  = sda_rise_i & scl_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
    end else if (start_c) begin
      busy_q <= 1'b1;
    end else if (stop_c) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_c || stop_c) begin
      cnt_q <= '0;
    end else if (scl_rise_i && busy_q) begin
      cnt_q <= (cnt_q == LAST) ? CNT_W'(1) : cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    evt_o.start = start_c;
    evt_o.stop  = stop_c;
    evt_o.fall8 = scl_fall_i & busy_q & (cnt_q == PRE_LAST);
    evt_o.rise9 = scl_rise_i & busy_q & (cnt_q == PRE_LAST);
    evt_o.sda   = sda_lvl_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/i2c_irq_evt.sv
module i2c_irq_evt
  import i2c_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  frame_evt_t fe_i,
  input  irq_ctrl_t  ctl_i,
  input  ext_evt_t   ext_i,
  input  logic       wr_en_i,
  input  logic       wr_flag_i,
  output logic       set_o,
  output logic       irq_o,
  output logic       ack_bit_o,
  output logic       stop_seen_o
);
  logic ff_pend_q, al_seen_q, slv_act_q;
  logic irq_q, ackb_q, stop_q;
  logic set_mst, set_slv, set_ack;
  logic addr_evt;

  assign addr_evt = ext_i.addr_match | ext_i.gcall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_pend_q <= 1'b0;
      al_seen_q <= 1'b0;
      slv_act_q <= 1'b0;
    end else begin
      if (ext_i.first_frame)  ff_pend_q <= 1'b1;
      else if (fe_i.start)    ff_pend_q <= 1'b0;

      if (ext_i.arb_lost)     al_seen_q <= 1'b1;
      else if (fe_i.stop)     al_seen_q <= 1'b0;

      if (fe_i.start || fe_i.stop)      slv_act_q <= 1'b0;
      else if (addr_evt && !ctl_i.master) slv_act_q <= 1'b1;
    end
  end

  always_comb begin
    set_mst = ctl_i.master & ((fe_i.start & ff_pend_q)
                            | (fe_i.fall8 & ctl_i.wait_en)
                            | fe_i.rise9
                            | (ext_i.arb_lost & ctl_i.al_ie));
    set_slv = ~ctl_i.master & ((fe_i.rise9 & slv_act_q)
                             | (fe_i.stop & ~ctl_i.stop_mask));
    set_ack = fe_i.rise9 & ctl_i.ack_chk & fe_i.sda;
    set_o   = set_mst | set_slv | set_ack | (al_seen_q & addr_evt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      ackb_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      // set has priority over a software clear
      if (set_o)                        irq_q <= 1'b1;
      else if (wr_en_i && !wr_flag_i)   irq_q <= 1'b0;

      if (fe_i.rise9) ackb_q <= fe_i.sda;

      if (fe_i.stop && !ctl_i.master) stop_q <= 1'b1;
      else if (fe_i.start)            stop_q <= 1'b0;
    end
  end

  assign irq_o       = irq_q;
  assign ack_bit_o   = ackb_q;
  assign stop_seen_o = stop_q;
endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag
  import i2c_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic master_i,
  input  logic wait_en_i,
  input  logic ack_chk_i,
  input  logic al_ie_i,
  input  logic stop_mask_i,
  input  logic arb_lost_i,
  input  logic addr_match_i,
  input  logic gcall_i,
  input  logic first_frame_i,
  input  logic wr_en_i,
  input  logic wr_flag_i,
  output logic irq_o,
  output logic ack_bit_o,
  output logic stop_seen_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  frame_evt_t fe;
  irq_ctrl_t  ctl;
  ext_evt_t   ext;
  logic [CNT_W-1:0] frame_cnt;
  logic set_evt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_frame_mon u_mon (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .evt_o(fe), .cnt_o(frame_cnt)
  );

  always_comb begin
    ctl.master    = master_i;
    ctl.wait_en   = wait_en_i;
    ctl.ack_chk   = ack_chk_i;
    ctl.al_ie     = al_ie_i;
    ctl.stop_mask = stop_mask_i;
    ext.arb_lost    = arb_lost_i;
    ext.addr_match  = addr_match_i;
    ext.gcall       = gcall_i;
    ext.first_frame = first_frame_i;
  end

  i2c_irq_evt u_evt (
    .clk_i, .rst_ni,
    .fe_i(fe), .ctl_i(ctl), .ext_i(ext),
    .wr_en_i, .wr_flag_i,
    .set_o(set_evt),
    .irq_o, .ack_bit_o, .stop_seen_o
  );
endmodule

// File: rtl/i2c_irq_flag_chk.sv
module i2c_irq_flag_chk
  import i2c_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             master_i,
  input logic             wr_en_i,
  input logic             wr_flag_i,
  input logic             irq_o,
  input logic             ack_bit_o,
  input logic             stop_seen_o,
  input logic             set_evt,
  input frame_evt_t       fe,
  input logic [CNT_W-1:0] frame_cnt
);
  p_clear_needs_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(wr_en_i && !wr_flag_i));

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> irq_o);

  p_write_one_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_flag_i && !irq_o && !set_evt) |=> !irq_o);

  p_ack_latch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe.rise9 |=> (ack_bit_o == $past(fe.sda)));

  p_stop_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe.stop && !master_i) |=> stop_seen_o);

  p_cond_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe.start || fe.stop) |=> (frame_cnt == '0));

  p_cnt_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_cnt <= CNT_W'(FRAME_CLKS));

  p_cond_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fe.start && fe.stop));
endmodule

bind i2c_irq_flag i2c_irq_flag_chk u_chk (
  .clk_i, .rst_ni, .master_i, .wr_en_i, .wr_flag_i,
  .irq_o, .ack_bit_o, .stop_seen_o,
  .set_evt(set_evt), .fe(fe), .frame_cnt(frame_cnt)
);

// File: tb/test_i2c_irq_flag.sv
module test_i2c_irq_flag;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic master = 1'b0, wait_en = 1'b0, ack_chk = 1'b0, al_ie = 1'b0, stop_mask = 1'b1;
  logic arb_lost = 1'b0, addr_match = 1'b0, gcall = 1'b0, first_frame = 1'b0;
  logic wr_en = 1'b0, wr_flag = 1'b0;
  logic irq, ackb, stop_seen;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  i2c_irq_flag i_i2c_irq_flag (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .master_i(master), .wait_en_i(wait_en), .ack_chk_i(ack_chk),
    .al_ie_i(al_ie), .stop_mask_i(stop_mask), .arb_lost_i(arb_lost),
    .addr_match_i(addr_match), .gcall_i(gcall), .first_frame_i(first_frame),
    .wr_en_i(wr_en), .wr_flag_i(wr_flag),
    .irq_o(irq), .ack_bit_o(ackb), .stop_seen_o(stop_seen)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_scl(input logic v); @(negedge clk); scl = v; idle(5); endtask
  task automatic line_sda(input logic v); @(negedge clk); sda = v; idle(5); endtask

  task automatic bus_start; line_sda(1'b1); line_scl(1'b1); line_sda(1'b0); line_scl(1'b0); endtask
  task automatic bus_stop;  line_scl(1'b0); line_sda(1'b0); line_scl(1'b1); line_sda(1'b1); endtask

  task automatic clk_bits(input int n);
    for (int i = 0; i < n; i++) begin
      line_sda(1'(i % 2));
      line_scl(1'b1);
      line_scl(1'b0);
    end
  endtask

  task automatic sw_write(input logic v);
    @(negedge clk); wr_en = 1'b1; wr_flag = v;
    @(negedge clk); wr_en = 1'b0; wr_flag = 1'b0;
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
    idle(2);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(irq, 1'b0, "R11 irq");
    check(ackb, 1'b0, "R11 ack_bit");
    check(stop_seen, 1'b0, "R11 stop_seen");
    rst_n = 1'b1;
    idle(3);

    // sweep mode x wait x acke x ack value over one byte (R2 R3 R4)
    for (int c = 0; c < 16; c++) begin
      logic m, w, a, k;
      {m, w, a, k} = 4'(c);
      master = m; wait_en = w; ack_chk = a; stop_mask = 1'b1;
      bus_start;
      sw_write(1'b0);
      check(irq, 1'b0, "R1 start without pending first frame");
      clk_bits(7);
      line_sda(1'b0); line_scl(1'b1); line_scl(1'b0);
      check(irq, m & w, "R2 8th fall");
      sw_write(1'b0);
      line_sda(k); line_scl(1'b1);
      check(irq, m | (a & k), "R3/R4 9th rise");
      check(ackb, k, "R4 ack latch");
      line_scl(1'b0);
      bus_stop;
      sw_write(1'b0);
    end

    // R1 first-frame start
    master = 1'b1; wait_en = 1'b0; ack_chk = 1'b0;
    strobe(first_frame);
    check(irq, 1'b0, "R1 no flag before start");
    bus_start;
    check(irq, 1'b1, "R1 first-frame start");
    bus_stop; sw_write(1'b0);

    // R5 arbitration loss
    al_ie = 1'b0;
    strobe(arb_lost);
    check(irq, 1'b0, "R5 al masked");
    strobe(addr_match);
    check(irq, 1'b1, "R5 address after al");
    sw_write(1'b0);
    al_ie = 1'b1;
    strobe(arb_lost);
    check(irq, 1'b1, "R5 al enabled");
    sw_write(1'b0);
    bus_start; bus_stop; sw_write(1'b0);
    strobe(gcall);
    check(irq, 1'b0, "R5 al record cleared by stop");
    al_ie = 1'b0;

    // R8 write semantics
    sw_write(1'b1);
    check(irq, 1'b0, "R8 write 1 while clear");
    @(negedge clk); arb_lost = 1'b1; al_ie = 1'b1;
    @(negedge clk); arb_lost = 1'b0; al_ie = 1'b0;
    sw_write(1'b1);
    check(irq, 1'b1, "R8 write 1 while set");
    idle(10);
    check(irq, 1'b1, "R8 holds without write");
    sw_write(1'b0);
    check(irq, 1'b0, "R8 write 0 clears");

    // R9 set and clear in same cycle
    @(negedge clk); arb_lost = 1'b1; al_ie = 1'b1; wr_en = 1'b1; wr_flag = 1'b0;
    @(negedge clk); arb_lost = 1'b0; al_ie = 1'b0; wr_en = 1'b0;
    check(irq, 1'b1, "R9 set wins");
    sw_write(1'b0);
    bus_stop; sw_write(1'b0);

    // R10 repeated start mid-byte restarts count
    master = 1'b1;
    bus_start; sw_write(1'b0);
    clk_bits(3);
    bus_start; sw_write(1'b0);
    clk_bits(8);
    check(irq, 1'b0, "R10 no event at old count");
    line_scl(1'b1);
    check(irq, 1'b1, "R10 9th rise from new start");
    line_scl(1'b0);
    bus_stop; sw_write(1'b0);

    // R6 slave active until repeated start; R7 stop handling
    master = 1'b0; ack_chk = 1'b0; stop_mask = 1'b1;
    bus_start;
    clk_bits(9);
    check(irq, 1'b0, "R6 slave idle no flag");
    strobe(addr_match);
    clk_bits(8); line_scl(1'b1);
    check(irq, 1'b1, "R6 slave byte 1");
    line_scl(1'b0); sw_write(1'b0);
    clk_bits(8); line_scl(1'b1);
    check(irq, 1'b1, "R6 slave byte 2");
    line_scl(1'b0); sw_write(1'b0);
    bus_start; sw_write(1'b0);
    clk_bits(9);
    check(irq, 1'b0, "R6 inactive after repeated start");
    bus_stop;
    check(irq, 1'b0, "R7 stop masked");
    check(stop_seen, 1'b1, "R7 stop status");
    bus_start;
    check(stop_seen, 1'b0, "R7 status cleared by start");
    stop_mask = 1'b0;
    strobe(gcall);
    bus_stop;
    check(irq, 1'b1, "R7 stop unmasked");
    sw_write(1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule